// File: doc/BRIEF.md
# CAN Sleep Wake-Up Controller

This block runs the sleep and wake-up sequence for the power-save logic of a CAN controller. When software asks for sleep, the internal clock domain is treated as gated. The receive line is watched by an edge-triggered latch that needs no clock. A recessive-to-dominant transition on the line is the wake-up event. If the wake-up interrupt is enabled, that event raises the interrupt flag at once, with no clock edge needed.

Wake-up then continues in a second, synchronous stage. The restarted clock brings the receive line through a synchronizer chain that starts out recessive. After the chain has been clocked once per stage, the first dominant level that follows a recessive sample completes the restart. If the line was still dominant when the chain settled, the first edge is captured. If the line had already gone recessive, restart waits for the next falling edge. The CAN stuffing rule puts such an edge within 10 bit times. Until restart completes, the mode status reads sleep, register access is not ready, and both flag-clear and sleep-request strobes have no effect. Software therefore polls the status and repeats the clear.

Top module: `canwk_ctrl`

## Requirements
- R1: After reset the mode status is 2'b00 (normal), the wake flag is 0 and the ready output is 1.
- R2: A sleep request sampled at a clock edge while the status is normal sets the status to 2'b01 (sleep) and drops ready after that same edge.
- R3: While asleep with the interrupt enable at 1, a falling edge on the receive line drives the wake flag to 1 before any further clock edge.
- R4: With the interrupt enable at 0, a wake-up leaves the wake flag at 0 for the whole sequence.
- R5: From the wake-up event until synchronous restart completes, the status stays 2'b01 and ready stays 0.
- R6: A flag-clear strobe sampled while the status is not normal leaves the wake flag unchanged.
- R7: With SYNC_STAGES=2, if the line is still dominant at the fourth clock edge after the wake-up edge, the status returns to 2'b00 at the sixth clock edge after the wake-up edge.
- R8: If the first dominant pulse ends before that fourth edge, restart waits for a later falling edge. The status returns to 2'b00 at the third clock edge after that later edge.
- R9: In normal mode, a flag-clear strobe sampled at a clock edge clears the wake flag after that edge.
- R10: A sleep request sampled while the status is not normal is ignored.
- R11: Receive-line activity in normal mode changes neither the wake flag nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| can_rx_i | input | 1 | CAN receive line, 1 = recessive |
| sleep_req_i | input | 1 | Request to enter sleep |
| wake_ie_i | input | 1 | Wake-up interrupt enable |
| flag_clr_i | input | 1 | Write strobe that clears the wake flag |
| psmode_o | output | 2 | Mode status: 2'b00 normal, 2'b01 sleep |
| wake_flag_o | output | 1 | Wake-up interrupt flag |
| reg_ready_o | output | 1 | Register access is effective |

## Verification
The bound checker watches four relations on every clock: a sleep request taken in normal mode, a flag that no strobe can clear while asleep, a clear that takes effect in normal mode, and the absence of wake-up in normal mode when no sleep is requested. Some behaviour only the bench's scenarios can show. This covers the flag rising with no clock edge, the choice between a captured and a missed first edge, and the exact edge at which restart completes. The bench shows these by sweeping the length of the dominant pulse and the interrupt enable, while hammering clear and sleep strobes through the whole window.

// File: rtl/canwk_pkg.sv
package canwk_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'b00,
        ST_SLEEP   = 2'b01,
        ST_RESTART = 2'b10
    } wk_state_e;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_SLEEP  = 2'b01;
endpackage

// File: rtl/canwk_edge_latch.sv
// Clockless capture of a falling edge on the line while armed.
module canwk_edge_latch (
    input  logic line_i,
    input  logic armed_i,
    output logic event_o
);
    logic event_q;

    always_ff @(negedge line_i or negedge armed_i) begin
        if (!armed_i) event_q <= 1'b0;
        else          event_q <= 1'b1;
    end

    assign event_o = event_q;
endmodule

// File: rtl/canwk_sync.sv
// Synchronizer chain; hold_i forces every stage to INIT (gated clock model).
module canwk_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        if (hold_i) sh_d = {STAGES{INIT}};
        else        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{INIT}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/canwk_ctrl.sv
module canwk_ctrl
    import canwk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       can_rx_i,
    input  logic       sleep_req_i,
    input  logic       wake_ie_i,
    input  logic       flag_clr_i,
    output logic [1:0] psmode_o,
    output logic       wake_flag_o,
    output logic       reg_ready_o
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] SETTLE = CNT_W'(SYNC_STAGES);

    typedef struct packed {
        wk_state_e        state;
        logic             armed;
        logic             flag;
        logic             rx_prev;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;
    logic  evt_async, evt_sync, rx_sync, rx_fall;

    canwk_edge_latch u_latch (
        .line_i  (can_rx_i),
        .armed_i (r_q.armed),
        .event_o (evt_async)
    );

    canwk_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_evt_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (!r_q.armed),
        .d_i    (evt_async),
        .q_o    (evt_sync)
    );

    // Receive chain stays recessive while the internal clock is gated.
    canwk_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rx_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (r_q.state == ST_SLEEP),
        .d_i    (can_rx_i),
        .q_o    (rx_sync)
    );

    assign rx_fall = r_q.rx_prev & ~rx_sync;

    always_comb begin
        r_d = r_q;
        r_d.rx_prev = (r_q.state == ST_SLEEP) ? 1'b1 : rx_sync;
        unique case (r_q.state)
            ST_NORMAL: begin
                if (flag_clr_i)  r_d.flag  = 1'b0;
                if (sleep_req_i) r_d.state = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (evt_sync) begin
                    r_d.state = ST_RESTART;
                    r_d.cnt   = '0;
                    // a wake-up event wins over any clear
                    if (wake_ie_i) r_d.flag = 1'b1;
                end
            end
            ST_RESTART: begin
                if (r_q.cnt != SETTLE)  r_d.cnt   = r_q.cnt + 1'b1;
                else if (rx_fall)       r_d.state = ST_NORMAL;
            end
            default: r_d.state = ST_NORMAL;
        endcase
        r_d.armed = (r_d.state == ST_SLEEP);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state   <= ST_NORMAL;
            r_q.armed   <= 1'b0;
            r_q.flag    <= 1'b0;
            r_q.rx_prev <= 1'b1;
            r_q.cnt     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign psmode_o    = (r_q.state == ST_NORMAL) ? MODE_NORMAL : MODE_SLEEP;
    assign reg_ready_o = (r_q.state == ST_NORMAL);
    assign wake_flag_o = r_q.flag | (evt_async & wake_ie_i & r_q.armed);
endmodule

// File: rtl/canwk_ctrl_chk.sv
module canwk_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       can_rx_i,
    input logic       sleep_req_i,
    input logic       wake_ie_i,
    input logic       flag_clr_i,
    input logic [1:0] psmode_o,
    input logic       wake_flag_o,
    input logic       reg_ready_o
);
    AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_ready_o && sleep_req_i) |=> (psmode_o == 2'b01 && !reg_ready_o)); // R2

    AST_CLEAR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psmode_o != 2'b00 && wake_flag_o) |=> wake_flag_o); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_ready_o && flag_clr_i) |=> !wake_flag_o); // R9

    AST_NORMAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_ready_o && !sleep_req_i && !wake_flag_o) |=> (!wake_flag_o && psmode_o == 2'b00)); // R11
endmodule

bind canwk_ctrl canwk_ctrl_chk u_chk (.*);

// File: tb/canwk_ctrl_test.sv
`timescale 1ns/1ps
module canwk_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       sleep_req = 1'b0;
    logic       ie = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] mode;
    logic       flag;
    logic       ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    canwk_ctrl uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .can_rx_i    (rx),
        .sleep_req_i (sleep_req),
        .wake_ie_i   (ie),
        .flag_clr_i  (clr),
        .psmode_o    (mode),
        .wake_flag_o (flag),
        .reg_ready_o (ready)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One sleep/wake cycle; len = dominant pulse length in cycles.
    task automatic trial(input int len, input bit en);
        bit cap  = (len >= 4);
        int done_i = cap ? 6 : 13;
        @(negedge clk);
        ie = en; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R2 mode", mode, 2'b01);
        chk("R2 ready", {1'b0, ready}, 2'b00);
        @(negedge clk);
        @(negedge clk);
        rx = 1'b0; clr = 1'b1; sleep_req = 1'b1;
        #1;
        chk(en ? "R3 async flag" : "R4 flag off", {1'b0, flag}, {1'b0, en});
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            chk(cap ? "R7 mode" : "R8 mode", mode, (i < done_i) ? 2'b01 : 2'b00);
            chk("R5 ready", {1'b0, ready}, {1'b0, (i >= done_i)});
            chk(en ? "R6 flag held" : "R4 flag off", {1'b0, flag}, {1'b0, en});
            if (i == len) rx = 1'b1;
            if (!cap && i == 10) rx = 1'b0;
            if (!cap && i == 12) rx = 1'b1;
            clr = (i < done_i);
            sleep_req = (i < done_i);
        end
        chk("R10 mode", mode, 2'b00);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R9 cleared", {1'b0, flag}, 2'b00);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 flag", {1'b0, flag}, 2'b00);
        chk("R11 mode", mode, 2'b00);
        rx = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode", mode, 2'b00);
        chk("R1 flag", {1'b0, flag}, 2'b00);
        chk("R1 ready", {1'b0, ready}, 2'b01);
        for (int e = 0; e < 2; e++)
            for (int l = 1; l <= 6; l++)
                trial(l, e[0]);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule